// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a flash device. Once a program or erase operation has been sent to the device by other logic, a single start pulse hands control to the poller. It then decides whether the operation completed by reading the device status word over and over and comparing the toggle bit across consecutive reads.

A toggle bit that holds its value across a pair of reads means the operation has finished. If the toggle bit is still moving, the poller looks at the error flag. When the error flag is clear, it reads another pair. When the error flag is set, it does one more pair of reads, because the toggle may have stopped in the same instant that the error flag rose. If that last pair still toggles, the poller itself writes the reset command to the device and reports a failure.

The poller also enforces a maximum number of polling pairs, so a device that never settles ends the run as a timeout failure. A suspend input lets the system pause polling at a pair boundary. On resume, polling starts again with a fresh pair.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it, busy_o, done_o, pass_o, fail_o, timeout_o and req_o are all 0.
- R2: A start_i pulse in the idle state begins a run that opens with two status reads (req_o=1, req_we_o=0). A start_i pulse while a run is in progress has no effect: the run still produces exactly one done_o pulse, and no second run follows.
- R3: When bit 6 (the toggle bit) of the first and second read of a pair is equal, the run ends with pass_o=1 and no write is made.
- R4: When bit 6 differs within a pair and bit 5 (the error flag) of the second read is 0, the poller issues a new pair of reads and compares only the two reads of that new pair.
- R5: When bit 6 differs and bit 5 of the second read is 1, the poller does exactly two more reads. If bit 6 of those two reads is equal, the run ends with pass_o=1.
- R6: When the recheck pair of R5 still differs in bit 6, the poller issues one write (req_we_o=1) with req_wdata_o=8'hF0 and then ends with fail_o=1 and timeout_o=0.
- R7: When MAX_PAIRS consecutive pairs each differ in bit 6 with bit 5 clear, the poller writes 8'hF0 and ends with fail_o=1 and timeout_o=1, after exactly 2*MAX_PAIRS reads.
- R8: Every accepted start gives exactly one single-cycle done_o pulse. In that cycle exactly one of pass_o and fail_o is 1. pass_o, fail_o and timeout_o hold their values until the next accepted start.
- R9: If suspend_i is high when a pair ends with the decision to loop, no request is issued while suspend_i stays high and busy_o stays 1. After suspend_i falls, polling restarts with a new pair whose first read is not compared against any read made before the pause.
- R10: Once req_o is raised, it stays high with req_we_o and req_wdata_o unchanged until a cycle with rsp_valid_i=1 completes the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin polling; accepted only when idle |
| suspend_i | input | 1 | Pause polling at the next pair boundary |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when a run ends |
| pass_o | output | 1 | Run ended with the operation complete |
| fail_o | output | 1 | Run ended in failure (error or timeout) |
| timeout_o | output | 1 | The failure was caused by the pair limit |
| req_o | output | 1 | Device transfer request, held until accepted |
| req_we_o | output | 1 | 1 = write transfer (reset command), 0 = status read |
| req_wdata_o | output | DATA_W | Write data for the transfer |
| rsp_valid_i | input | 1 | Device completes the current transfer this cycle |
| rsp_data_i | input | DATA_W | Status word returned with a read completion |

## Verification
The assertions check on every cycle that done_o is a single pulse carrying exactly one verdict, that a timeout is always reported as a failure, that a pending request keeps its fields stable until it is accepted, that the pair counter never passes its limit, and that busy_o only rises after a start. Only the bench scenarios can show the decision sequence itself. This covers how many reads each pattern of toggle and error bits uses, that the verdict matches the pair logic, that exactly one 8'hF0 write appears on the failure paths, and that a resumed run ignores the reads made before the pause. They also show that a start during a run is ignored. Random status streams with random device latency are compared against a bench model of the polling decisions.

// File: rtl/toggle_poll_pkg.sv
// Shared types for the toggle-bit completion poller.
// Assumes: used only by the poller modules in this directory.
package toggle_poll_pkg;

    // Controller states, one per phase of a polling run.
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PAIR_A   = 3'd1,
        ST_PAIR_B   = 3'd2,
        ST_RECHK_A  = 3'd3,
        ST_RECHK_B  = 3'd4,
        ST_HOLD     = 3'd5,
        ST_RESET_WR = 3'd6,
        ST_FINISH   = 3'd7
    } poll_state_t;

endpackage

// File: rtl/toggle_sample_cmp.sv
// Keeps the toggle bit of the first read of a pair and compares it with
// the current read response.
// Assumes: capture_i and clear_i are never high in the same cycle; after a
// clear, differ_o stays 0 until a new first sample has been captured.
module toggle_sample_cmp #(
    parameter int DATA_W  = 8,
    parameter int TOG_BIT = 6,
    parameter int ERR_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic              clear_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic              differ_o,
    output logic              err_o
);

    logic first_q;
    logic first_vld_q;

    // Hold the first toggle sample of the current pair.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            first_q     <= 1'b0;
            first_vld_q <= 1'b0;
        end else if (capture_i) begin
            first_q     <= sample_i[TOG_BIT];
            first_vld_q <= 1'b1;
        end
    end

    // Compare the live second sample with the stored first one.
    always_comb begin
        differ_o = first_vld_q && (sample_i[TOG_BIT] != first_q);
        err_o    = sample_i[ERR_BIT];
    end

endmodule

// File: rtl/poll_pair_counter.sv
// Counts completed looping pairs and flags the last allowed pair.
// Assumes: inc_i is never asserted while last_o is high.
module poll_pair_counter #(
    parameter int MAX_PAIRS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);

    localparam int CW = $clog2(MAX_PAIRS + 1);

    logic [CW-1:0] cnt_q;

    // Advance once per looping pair, clear at the start of a run.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Flag the pair that may not be followed by another.
    always_comb begin
        last_o = (cnt_q == CW'(MAX_PAIRS - 1));
    end

    // R7: the count stays below the limit.
    assert_cnt_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(MAX_PAIRS));

    // R7: the controller never advances past the last pair.
    assert_no_inc_past_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |-> !last_o);

endmodule

// File: rtl/toggle_poll_ctrl.sv
// Host-side completion poller. After start it reads the device status in
// pairs and compares bit TOG_BIT. If the bit holds, the run passes. If it
// moves with ERR_BIT clear, the poller reads another pair. If it moves with
// ERR_BIT set, the poller reads one recheck pair and passes only if that pair
// holds. Otherwise it writes RESET_CMD and fails. MAX_PAIRS looping pairs
// end the run as a timeout failure.
// Assumes: the device completes each transfer by raising rsp_valid_i for one
// cycle while req_o is high, with read data on rsp_data_i in that cycle.
module toggle_poll_ctrl #(
    parameter int                DATA_W    = 8,
    parameter int                TOG_BIT   = 6,
    parameter int                ERR_BIT   = 5,
    parameter int                MAX_PAIRS = 1024,
    parameter logic [DATA_W-1:0] RESET_CMD = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              suspend_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              pass_o,
    output logic              fail_o,
    output logic              timeout_o,
    output logic              req_o,
    output logic              req_we_o,
    output logic [DATA_W-1:0] req_wdata_o,
    input  logic              rsp_valid_i,
    input  logic [DATA_W-1:0] rsp_data_i
);

    import toggle_poll_pkg::*;

    poll_state_t state_q, state_d;

    logic capture, clr_cmp, cnt_clr, cnt_inc;
    logic set_pass, set_fail, set_to, accept_start;
    logic differ, err_flag, last_pair;
    logic pass_q, fail_q, to_q;
    logic unused_rsp_bits;

    assign unused_rsp_bits = ^rsp_data_i;

    toggle_sample_cmp #(
        .DATA_W  (DATA_W),
        .TOG_BIT (TOG_BIT),
        .ERR_BIT (ERR_BIT)
    ) cmp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .clear_i   (clr_cmp),
        .sample_i  (rsp_data_i),
        .differ_o  (differ),
        .err_o     (err_flag)
    );

    poll_pair_counter #(
        .MAX_PAIRS (MAX_PAIRS)
    ) ctr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cnt_clr),
        .inc_i  (cnt_inc),
        .last_o (last_pair)
    );

    // Next-state and control decode for the polling sequence.
    always_comb begin
        state_d      = state_q;
        req_o        = 1'b0;
        req_we_o     = 1'b0;
        capture      = 1'b0;
        clr_cmp      = 1'b0;
        cnt_clr      = 1'b0;
        cnt_inc      = 1'b0;
        set_pass     = 1'b0;
        set_fail     = 1'b0;
        set_to       = 1'b0;
        accept_start = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    accept_start = 1'b1;
                    clr_cmp      = 1'b1;
                    cnt_clr      = 1'b1;
                    state_d      = ST_PAIR_A;
                end
            end
            ST_PAIR_A: begin
                req_o = 1'b1;
                if (rsp_valid_i) begin
                    capture = 1'b1;
                    state_d = ST_PAIR_B;
                end
            end
            ST_PAIR_B: begin
                req_o = 1'b1;
                if (rsp_valid_i) begin
                    if (!differ) begin
                        set_pass = 1'b1;
                        state_d  = ST_FINISH;
                    end else if (err_flag) begin
                        state_d = ST_RECHK_A;
                    end else if (last_pair) begin
                        set_fail = 1'b1;
                        set_to   = 1'b1;
                        state_d  = ST_RESET_WR;
                    end else begin
                        cnt_inc = 1'b1;
                        clr_cmp = 1'b1;
                        state_d = suspend_i ? ST_HOLD : ST_PAIR_A;
                    end
                end
            end
            ST_RECHK_A: begin
                req_o = 1'b1;
                if (rsp_valid_i) begin
                    capture = 1'b1;
                    state_d = ST_RECHK_B;
                end
            end
            ST_RECHK_B: begin
                req_o = 1'b1;
                if (rsp_valid_i) begin
                    if (!differ) begin
                        set_pass = 1'b1;
                        state_d  = ST_FINISH;
                    end else begin
                        set_fail = 1'b1;
                        state_d  = ST_RESET_WR;
                    end
                end
            end
            ST_HOLD: begin
                if (!suspend_i) begin
                    state_d = ST_PAIR_A;
                end
            end
            ST_RESET_WR: begin
                req_o    = 1'b1;
                req_we_o = 1'b1;
                if (rsp_valid_i) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Verdict flags: cleared by an accepted start, set by a decision.
    always_ff @(posedge clk) begin
        if (!rst_n || accept_start) begin
            pass_q <= 1'b0;
            fail_q <= 1'b0;
            to_q   <= 1'b0;
        end else begin
            if (set_pass) pass_q <= 1'b1;
            if (set_fail) fail_q <= 1'b1;
            if (set_to)   to_q   <= 1'b1;
        end
    end

    // Output drive from state and verdict registers.
    always_comb begin
        busy_o      = (state_q != ST_IDLE) && (state_q != ST_FINISH);
        done_o      = (state_q == ST_FINISH);
        pass_o      = pass_q;
        fail_o      = fail_q;
        timeout_o   = to_q;
        req_wdata_o = req_we_o ? RESET_CMD : '0;
    end

    // R8: done is a single-cycle pulse.
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: done carries exactly one verdict.
    assert_done_verdict_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pass_o ^ fail_o));

    // R7: a timeout is always a failure.
    assert_timeout_is_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && timeout_o) |-> fail_o);

    // R10: a pending request keeps its fields until accepted.
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !rsp_valid_i) |=> (req_o && $stable(req_we_o) && $stable(req_wdata_o)));

    // R2: busy only rises after a start request.
    assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R6: no reset write is made on a run already judged as passing.
    assert_write_not_on_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && req_we_o) |-> (fail_o && !pass_o));

endmodule

// File: tb/toggle_poll_ctrl_tb_top.sv
`timescale 1ns/1ps
module toggle_poll_ctrl_tb_top;

    localparam int MAXP = 6;
    localparam int SLEN = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       suspend = 1'b0;
    logic       busy, done, pass_w, fail_w, to_w;
    logic       req, req_we;
    logic [7:0] req_wdata;
    logic       rsp_valid = 1'b0;
    logic [7:0] rsp_data = 8'h00;

    logic [7:0] script [SLEN];
    int         rd_idx = 0;
    int         wr_cnt = 0;
    logic [7:0] last_wdata = 8'h00;
    int         checks = 0;
    int         failures = 0;

    always #4 clk = ~clk;

    toggle_poll_ctrl #(
        .DATA_W    (8),
        .TOG_BIT   (6),
        .ERR_BIT   (5),
        .MAX_PAIRS (MAXP),
        .RESET_CMD (8'hF0)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .suspend_i   (suspend),
        .busy_o      (busy),
        .done_o      (done),
        .pass_o      (pass_w),
        .fail_o      (fail_w),
        .timeout_o   (to_w),
        .req_o       (req),
        .req_we_o    (req_we),
        .req_wdata_o (req_wdata),
        .rsp_valid_i (rsp_valid),
        .rsp_data_i  (rsp_data)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Device model: random latency, serves reads from the script, logs writes.
    initial begin
        int   lat;
        logic we0;
        forever begin
            @(negedge clk);
            rsp_valid = 1'b0;
            if (req) begin
                lat = $urandom_range(0, 3);
                we0 = req_we;
                repeat (lat) begin
                    @(negedge clk);
                    check(req && (req_we == we0), "R10", "request held", int'(req), 1);
                end
                if (we0) begin
                    wr_cnt++;
                    last_wdata = req_wdata;
                    rsp_data = 8'h00;
                end else begin
                    rsp_data = script[rd_idx % SLEN];
                    rd_idx++;
                end
                rsp_valid = 1'b1;
            end
        end
    end

    // Expected outcome of the polling decisions on the current script.
    // Outcome codes: 1 pass, 2 fail, 3 timeout.
    function automatic void model(output int outc, output int nreads, output int nwr);
        int idx = 0;
        int pairs = 0;
        bit fin = 0;
        outc = 0;
        nwr = 0;
        while (!fin) begin
            if (script[idx][6] == script[idx+1][6]) begin
                outc = 1;
                fin = 1;
                idx += 2;
            end else if (script[idx+1][5]) begin
                idx += 2;
                outc = (script[idx][6] == script[idx+1][6]) ? 1 : 2;
                idx += 2;
                fin = 1;
            end else begin
                idx += 2;
                pairs++;
                if (pairs == MAXP) begin
                    outc = 3;
                    fin = 1;
                end
            end
        end
        if (outc != 1) nwr = 1;
        nreads = idx;
    endfunction

    task automatic run_case(input string tag, input bit use_susp, input bit extra_start);
        int  outc, nreads, nwr, n;
        bit  got;
        bit  exp_pass, exp_fail, exp_to;
        model(outc, nreads, nwr);
        exp_pass = (outc == 1);
        exp_fail = (outc != 1);
        exp_to   = (outc == 3);
        rd_idx = 0;
        wr_cnt = 0;
        last_wdata = 8'h00;
        @(negedge clk);
        start = 1'b1;
        suspend = use_susp;
        @(negedge clk);
        start = 1'b0;
        got = 0;
        n = 0;
        if (done) got = 1;
        if (use_susp) begin
            while (rd_idx < 2 && n < 200) begin
                @(negedge clk);
                n++;
            end
            repeat (20) @(negedge clk);
            check(rd_idx == 2, "R9", "reads while suspended", rd_idx, 2);
            check(busy && !done, "R9", "busy held while suspended", int'(busy), 1);
            suspend = 1'b0;
        end
        if (extra_start) begin
            while (rd_idx < 1 && n < 200) begin
                @(negedge clk);
                n++;
            end
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!got && n < 2000) begin
            @(negedge clk);
            n++;
            if (done) got = 1;
        end
        check(got, tag, "done seen", int'(got), 1);
        check(pass_w == exp_pass, tag, "pass", int'(pass_w), int'(exp_pass));
        check(fail_w == exp_fail, tag, "fail", int'(fail_w), int'(exp_fail));
        check(to_w == exp_to, tag, "timeout", int'(to_w), int'(exp_to));
        check(rd_idx == nreads, tag, "read count", rd_idx, nreads);
        check(wr_cnt == nwr, tag, "write count", wr_cnt, nwr);
        if (nwr != 0)
            check(last_wdata == 8'hF0, "R6", "reset command value", int'(last_wdata), 'hF0);
        repeat (4) begin
            @(negedge clk);
            check(!done && !busy, "R8", "single done then idle", int'(done), 0);
            check(pass_w == exp_pass && fail_w == exp_fail && to_w == exp_to,
                  "R8", "verdict held", int'(pass_w), int'(exp_pass));
        end
        if (extra_start)
            check(rd_idx == nreads, "R2", "no second run from ignored start", rd_idx, nreads);
    endtask

    task automatic fill_alt();
        for (int i = 0; i < SLEN; i++) script[i] = (i % 2 == 1) ? 8'h40 : 8'h00;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        fill_alt();
        repeat (3) @(negedge clk);
        check(!busy && !done && !pass_w && !fail_w && !to_w && !req, "R1",
              "outputs in reset", int'(busy | done | req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !pass_w && !fail_w && !to_w && !req, "R1",
              "outputs after reset", int'(busy | done | req), 0);

        // R3: stable toggle on the first pair.
        fill_alt(); script[0] = 8'h00; script[1] = 8'h00;
        run_case("R3", 1'b0, 1'b0);
        // R4: one toggling pair, then a stable one.
        fill_alt(); script[2] = 8'h40; script[3] = 8'h40;
        run_case("R4", 1'b0, 1'b0);
        // R5: error flag seen, recheck pair stable.
        fill_alt(); script[1] = 8'h60; script[2] = 8'h40; script[3] = 8'h40;
        run_case("R5", 1'b0, 1'b0);
        // R6: error flag seen, recheck still toggling.
        fill_alt(); script[1] = 8'h60; script[2] = 8'h00; script[3] = 8'h40;
        run_case("R6", 1'b0, 1'b0);
        // R7: toggling forever without error.
        fill_alt();
        run_case("R7", 1'b0, 1'b0);
        // R9: pause after a looping pair; fresh pair after resume.
        fill_alt(); script[1] = 8'h40; script[2] = 8'h00; script[3] = 8'h00;
        run_case("R9", 1'b1, 1'b0);
        // R2: start pulse during a run is ignored.
        fill_alt(); script[2] = 8'h40; script[3] = 8'h40;
        run_case("R2", 1'b0, 1'b1);

        // Random status streams.
        for (int t = 0; t < 30; t++) begin
            for (int i = 0; i < SLEN; i++) begin
                script[i] = 8'($urandom);
                script[i][5] = ($urandom_range(0, 3) == 0);
                if ($urandom_range(0, 2) != 0) script[i][6] = ~i[0];
            end
            run_case("R4", 1'b0, 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule